// File: doc/BRIEF.md
# Arbitrated Interrupt Vector Responder

This block sits between sixteen timer channels and a host processor's interrupt acknowledge path. Each channel raises a request bit and has its own enable bit. The block continuously picks the most urgent pending, enabled channel. When the host acknowledges the interrupt level assigned to this block, the block competes with other interrupt sources on a shared wired-OR line by sending its 4-bit arbitration ID, one bit per cycle. A source whose ID is higher survives this contest.

The winner places an 8-bit vector on the data bus for one cycle. The vector's upper nibble is a software-loaded base and its lower nibble is the number of the serviced channel. One cycle later the block pulses a clear for that channel's request bit. The base and ID inputs come from registers that reset to zero. Software must therefore load a base before it enables any channel, and an ID of zero keeps the block out of every acknowledge cycle.

Top module: `irq_vector_responder`

## Requirements
- R1: While reset is asserted and right after it, `arb_out`, `vec_valid`, `vec_out` and `req_clr` are all zero.
- R2: When several channels have both request and enable set, the channel with the lowest index is served.
- R3: The driven vector is `{vec_base, channel}`, with the base in bits 7:4 and the channel number in bits 3:0. Both values are captured when arbitration starts.
- R4: An acknowledge is sampled on a clock edge. In the four cycles after that edge, `arb_out` carries `arb_id` bits 3, 2, 1, 0 in that order while the block is still bidding, and is 0 otherwise.
- R5: If the block drives 0 in a bit cycle and sees 1 on `arb_line`, it drives 0 for the rest of the contest, never asserts `vec_valid`, and never pulses `req_clr`.
- R6: With `arb_id` equal to 0, an acknowledge causes no drive on `arb_out`, no vector and no clear.
- R7: An acknowledge whose `ack_level` differs from `irq_level` has no effect.
- R8: An acknowledge while no channel has both request and enable set has no effect.
- R9: After a win, `req_clr` is one-hot on the serviced channel for exactly the cycle following the vector cycle.
- R10: After a win, `vec_valid` is high for exactly one cycle, the fifth cycle after the edge that sampled the acknowledge.
- R11: An acknowledge strobe that arrives while a contest, vector or clear cycle is in progress is ignored, and no second contest follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | 16 | Per-channel interrupt request bits |
| chan_en | input | 16 | Per-channel interrupt enable bits |
| vec_base | input | 4 | Upper nibble of the vector |
| arb_id | input | 4 | Arbitration ID; 0 disables participation |
| irq_level | input | 3 | Interrupt level assigned to this block |
| ack_strobe | input | 1 | Single-cycle acknowledge start |
| ack_level | input | 3 | Level being acknowledged |
| arb_line | input | 1 | Resolved wired-OR arbitration line |
| arb_out | output | 1 | This block's contribution to the arbitration line |
| vec_out | output | 8 | Vector, zero when not valid |
| vec_valid | output | 1 | Vector strobe |
| req_clr | output | 16 | One-hot request clear for the serviced channel |

## Verification
A fresh acknowledge strobe can land in the same cycle as a busy phase of the previous one: during a bit cycle, the vector cycle, or the clear pulse. The bench raises the strobe in a bit cycle and again in the clear cycle. It judges the outcome by whether the vector and clear of the running contest stay correct and whether `arb_out` stays low afterwards. A competing bidder modelled in the bench resolves the shared line in the same cycle in which the block drops out.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_VEC  = 2'd2,
    ST_CLR  = 2'd3
  } irqv_state_e;
endpackage

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] pend,
  output logic              any,
  output logic [CH_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqv_bidder.sv
module irqv_bidder (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  logic id_bit,
  input  logic line,
  output logic drive,
  output logic bid_next
);
  logic bid_q;

  assign drive = step & bid_q & id_bit;

  always_comb begin
    bid_next = bid_q;
    if (load)
      bid_next = 1'b1;
    else if (step && !id_bit && line)
      bid_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bid_q <= 1'b0;
    else if (load || step)
      bid_q <= bid_next;
  end
endmodule

// File: rtl/irqv_onehot.sv
module irqv_onehot #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              en,
  input  logic [CH_W-1:0]   idx,
  output logic [NUM_CH-1:0] hot
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign hot[g] = en && (idx == CH_W'(g));
  end
endmodule

// File: rtl/irq_vector_responder.sv
module irq_vector_responder #(
  parameter int NUM_CH = 16,
  parameter int BASE_W = 4,
  parameter int ID_W   = 4,
  parameter int LVL_W  = 3,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int VEC_W = BASE_W + CH_W,
  localparam int CNT_W = $clog2(ID_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_req,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [BASE_W-1:0] vec_base,
  input  logic [ID_W-1:0]   arb_id,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              ack_strobe,
  input  logic [LVL_W-1:0]  ack_level,
  input  logic              arb_line,
  output logic              arb_out,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_valid,
  output logic [NUM_CH-1:0] req_clr
);
  import irqv_pkg::*;

  irqv_state_e       state_q, state_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [CH_W-1:0]   ch_q;
  logic [BASE_W-1:0] base_q;
  logic [ID_W-1:0]   id_q;
  logic              any_pend, start, arb_active, bid_next;
  logic [CH_W-1:0]   win_ch;

  irqv_prio_enc #(.NUM_CH(NUM_CH)) u_prio (
    .pend (chan_req & chan_en),
    .any  (any_pend),
    .idx  (win_ch)
  );

  assign start = (state_q == ST_IDLE) && ack_strobe && (ack_level == irq_level)
               && any_pend && (arb_id != '0);
  assign arb_active = (state_q == ST_ARB);

  irqv_bidder u_bid (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .step     (arb_active),
    .id_bit   (id_q[bit_q]),
    .line     (arb_line),
    .drive    (arb_out),
    .bid_next (bid_next)
  );

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_ARB;
        bit_d   = CNT_W'(ID_W - 1);
      end
      ST_ARB: begin
        if (bit_q == '0)
          state_d = bid_next ? ST_VEC : ST_IDLE;
        else
          bit_d = bit_q - 1'b1;
      end
      ST_VEC:  state_d = ST_CLR;
      ST_CLR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      base_q <= '0;
      id_q   <= '0;
    end else if (start) begin
      ch_q   <= win_ch;
      base_q <= vec_base;
      id_q   <= arb_id;
    end
  end

  assign vec_valid = (state_q == ST_VEC);
  assign vec_out   = vec_valid ? {base_q, ch_q} : '0;

  irqv_onehot #(.NUM_CH(NUM_CH)) u_clr (
    .en  (state_q == ST_CLR),
    .idx (ch_q),
    .hot (req_clr)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int NUM_CH = 16,
  parameter int VEC_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arb_out,
  input logic              arb_line,
  input logic              arb_active,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_out,
  input logic [NUM_CH-1:0] req_clr
);
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_active |-> !arb_out);

  p_drop_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_active && !arb_out && arb_line) |=> (!arb_out && !vec_valid));

  p_vec_after_arb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(arb_active));

  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_clr));

  p_clr_follows_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> (req_clr == (NUM_CH'(1) << $past(vec_out[CH_W-1:0]))));

  p_clr_needs_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr != '0) |-> $past(vec_valid));
endmodule

bind irq_vector_responder irqv_checker #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arb_out    (arb_out),
  .arb_line   (arb_line),
  .arb_active (arb_active),
  .vec_valid  (vec_valid),
  .vec_out    (vec_out),
  .req_clr    (req_clr)
);

// File: tb/irq_vector_responder_test.sv
module irq_vector_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] chan_req = '0, chan_en = '0;
  logic [3:0]  vec_base = '0, arb_id = '0;
  logic [2:0]  irq_level = 3'd5, ack_level = '0;
  logic        ack_strobe = 1'b0, comp_drive = 1'b0;
  logic        arb_line, arb_out, vec_valid;
  logic [7:0]  vec_out;
  logic [15:0] req_clr;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;
  assign arb_line = arb_out | comp_drive;

  irq_vector_responder uut (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_en(chan_en),
    .vec_base(vec_base), .arb_id(arb_id), .irq_level(irq_level),
    .ack_strobe(ack_strobe), .ack_level(ack_level), .arb_line(arb_line),
    .arb_out(arb_out), .vec_out(vec_out), .vec_valid(vec_valid), .req_clr(req_clr)
  );

  // {req, en, base, id, competitor id, level matches}
  localparam logic [44:0] CASES [8] = '{
    {16'h0010, 16'hFFFF, 4'hA, 4'h9, 4'h3, 1'b1},
    {16'h8001, 16'h8001, 4'h5, 4'hF, 4'hE, 1'b1},
    {16'h8000, 16'hFFFF, 4'hC, 4'h1, 4'h0, 1'b1},
    {16'h00F0, 16'h00C0, 4'h3, 4'h6, 4'h7, 1'b1},
    {16'h0003, 16'h0003, 4'h7, 4'h0, 4'h0, 1'b1},
    {16'h1234, 16'h0000, 4'h2, 4'h8, 4'h0, 1'b1},
    {16'h0100, 16'h0100, 4'h9, 4'hA, 4'h2, 1'b0},
    {16'h0C00, 16'h0800, 4'hE, 4'h8, 4'h7, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [44:0] c, input int ack_again);
    logic [15:0] req, en, pend;
    logic [3:0]  base, id, cid;
    logic        lvl_ok, part, win, our_bid, comp_bid, ob, cb;
    int          ch;
    string       tag;
    {req, en, base, id, cid, lvl_ok} = c;
    pend = req & en;
    ch = 0;
    for (int i = 15; i >= 0; i--) if (pend[i]) ch = i;
    part = lvl_ok && (pend != 0) && (id != 0);
    win  = part && (id > cid);
    if (id == 0) tag = "R6";
    else if (!lvl_ok) tag = "R7";
    else if (pend == 0) tag = "R8";
    else if (!win) tag = "R5";
    else tag = "R10";
    @(negedge clk);
    chan_req = req; chan_en = en; vec_base = base; arb_id = id;
    ack_level = lvl_ok ? 3'd5 : 3'd2;
    ack_strobe = 1'b1;
    our_bid = part;
    comp_bid = (cid != 0);
    for (int s = 1; s <= 4; s++) begin
      @(negedge clk);
      ack_strobe = (s == ack_again);
      ob = our_bid & id[4-s];
      cb = comp_bid & cid[4-s];
      comp_drive = cb;
      #1;
      check("R4 arb bit", {31'd0, arb_out}, {31'd0, ob});
      if (!ob && (ob | cb)) our_bid = 1'b0;
      if (!cb && (ob | cb)) comp_bid = 1'b0;
    end
    @(negedge clk);
    comp_drive = 1'b0;
    ack_strobe = (ack_again == 5);
    check({tag, " vec_valid"}, {31'd0, vec_valid}, {31'd0, win});
    if (win) check("R2 R3 vector", {24'd0, vec_out}, {24'd0, base, 4'(ch)});
    @(negedge clk);
    ack_strobe = (ack_again == 6);
    check("R9 req_clr", {16'd0, req_clr}, win ? (32'd1 << ch) : 32'd0);
    @(negedge clk);
    ack_strobe = 1'b0;
    check(ack_again != 0 ? "R11 idle" : "R4 idle",
          {30'd0, arb_out, vec_valid}, 32'd0);
    @(negedge clk);
    check(ack_again != 0 ? "R11 quiet" : "R9 quiet",
          {15'd0, vec_valid, req_clr}, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    chan_req = 16'hFFFF; chan_en = 16'hFFFF; arb_id = 4'h9; ack_level = 3'd5;
    ack_strobe = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {7'd0, arb_out, vec_valid, vec_out, req_clr}, 32'd0);
    ack_strobe = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {7'd0, arb_out, vec_valid, vec_out, req_clr}, 32'd0);

    foreach (CASES[i]) run_case(CASES[i], 0);

    // R11: strobe during a bit cycle, and in the clear cycle
    run_case(CASES[0], 2);
    run_case(CASES[7], 6);
    run_case(CASES[1], 5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule